// File: doc/BRIEF.md
# Bus Stall Timeout Recorder

This block watches two buses of a processor core, the instruction bus and the data bus. A bus is stalled in any cycle where its monitor is enabled, a request is outstanding and the target still reports busy. Each bus has a counter that adds up the consecutive stalled cycles. When the count reaches that bus's programmable limit, the block raises a sticky timeout flag and captures the offending access.

Each bus keeps two record slots. Slot 0 freezes the first timeout seen since the flag was last cleared. Slot 1 is overwritten by every timeout. An instruction-bus record packs the word address, the write flag and the load/store flag. A data-bus record keeps the byte enables and write flag, the word address, and the program counter current at the time of the timeout.

Software-visible configuration (enables, limits, interrupt enables, clear pulses) arrives as plain inputs. The flags and records are plain outputs.

Top module: `bus_stall_recorder`

## Requirements
- R1: After reset the flags, the interrupt and every record field are 0.
- R2: Index 0 of `mon_en`, `irq_en`, `clr` and `raw` belongs to the instruction bus and index 1 to the data bus. A bus is stalled in a cycle where its `mon_en` bit, its `*_req` and its `*_busy` are all 1. When a bus has been stalled for exactly L consecutive cycles with L = its limit and L nonzero, its `raw` bit is 1 from the next clock edge on.
- R3: One cycle that is not stalled restarts the count from zero. This covers the request dropping, busy falling and the monitor being disabled.
- R4: A limit of 0 never raises the flag, however long the stall lasts.
- R5: An instruction-bus record is {load/store flag in bit 31, write flag in bit 30, byte address bits 31:2 in bits 29:0}.
- R6: A data-bus record has three fields. `db_info*` holds byte enables in bits 4:1 and the write flag in bit 0. `db_addr*` holds byte address bits 31:2. `db_pc*` holds the `pc` input sampled in the timeout cycle.
- R7: Slot 0 is written only by a timeout that occurs while the flag is clear or is being cleared in the same cycle. It stays unchanged while the flag is set. Slot 1 is written by every timeout.
- R8: A 1 on a `clr` bit clears that flag at the next edge. If a timeout of the same bus occurs in that same cycle, the timeout wins: the flag stays set and both slots record the access.
- R9: `irq` is 1 in the same cycle whenever some `raw` bit is 1 together with its `irq_en` bit.
- R10: While one stall continues past its limit, the counter holds and no further timeout occurs. A new stall that reaches the limit raises a new timeout, which updates slot 1.
- R11: The two buses count, flag and record independently, each against its own limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mon_en | input | 2 | Monitor enable per bus |
| irq_en | input | 2 | Interrupt enable per bus |
| clr | input | 2 | Flag clear pulse per bus |
| lim_ib | input | 20 | Instruction-bus cycle limit |
| lim_db | input | 20 | Data-bus cycle limit |
| ib_req | input | 1 | Instruction request outstanding |
| ib_busy | input | 1 | Instruction target busy |
| ib_addr | input | 32 | Instruction byte address |
| ib_wr | input | 1 | Instruction-bus write |
| ib_ldst | input | 1 | Access is a load/store on the instruction bus |
| db_req | input | 1 | Data request outstanding |
| db_busy | input | 1 | Data target busy |
| db_addr | input | 32 | Data byte address |
| db_wr | input | 1 | Data write |
| db_be | input | 4 | Data byte enables |
| pc | input | 32 | Current program counter |
| raw | output | 2 | Sticky timeout flags |
| irq | output | 1 | Interrupt |
| ib_rec0 | output | 32 | Instruction record, first since clear |
| ib_rec1 | output | 32 | Instruction record, latest |
| db_info0 | output | 5 | Data byte enables and write, first |
| db_addr0 | output | 30 | Data word address, first |
| db_pc0 | output | 32 | Data PC, first |
| db_info1 | output | 5 | Data byte enables and write, latest |
| db_addr1 | output | 30 | Data word address, latest |
| db_pc1 | output | 32 | Data PC, latest |

## Verification
The hardest state to reach from the ports is a timeout that lands in exactly the cycle a clear is applied. That is the only case where slot 0 is rewritten while the flag reads as set. It needs the stall length and the clear pulse aligned to the cycle.

A directed sequence produces it with a limit of 2. The same holds for a second, separate stall that re-times-out while the flag is still set.

The random phase runs long busy streaks with small limits on both buses at once. Clears are rare in it, so repeated timeouts accumulate in slot 1 while slot 0 stays frozen.

// File: rtl/bus_stall_recorder.sv
module bus_stall_recorder #(
  parameter int CNT_W  = 20,
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mon_en,
  input  logic [1:0]        irq_en,
  input  logic [1:0]        clr,
  input  logic [CNT_W-1:0]  lim_ib,
  input  logic [CNT_W-1:0]  lim_db,
  input  logic              ib_req,
  input  logic              ib_busy,
  input  logic [ADDR_W-1:0] ib_addr,
  input  logic              ib_wr,
  input  logic              ib_ldst,
  input  logic              db_req,
  input  logic              db_busy,
  input  logic [ADDR_W-1:0] db_addr,
  input  logic              db_wr,
  input  logic [BE_W-1:0]   db_be,
  input  logic [PC_W-1:0]   pc,
  output logic [1:0]        raw,
  output logic              irq,
  output logic [ADDR_W-1:0] ib_rec0,
  output logic [ADDR_W-1:0] ib_rec1,
  output logic [BE_W:0]     db_info0,
  output logic [ADDR_W-3:0] db_addr0,
  output logic [PC_W-1:0]   db_pc0,
  output logic [BE_W:0]     db_info1,
  output logic [ADDR_W-3:0] db_addr1,
  output logic [PC_W-1:0]   db_pc1
);
  localparam int WA = ADDR_W - 2;

  logic             stall [2];
  logic             hit   [2];
  logic             fresh [2];
  logic             raw_q [2];
  logic [CNT_W-1:0] lim   [2];
  logic [CNT_W-1:0] cnt   [2];

  assign lim[0]   = lim_ib;
  assign lim[1]   = lim_db;
  assign stall[0] = mon_en[0] & ib_req & ib_busy;
  assign stall[1] = mon_en[1] & db_req & db_busy;
  assign raw      = {raw_q[1], raw_q[0]};
  assign irq      = |(raw & irq_en);

  for (genvar g = 0; g < 2; g++) begin : g_bus
    assign hit[g]   = stall[g] && (lim[g] != '0) &&
                      (({1'b0, cnt[g]} + 1'b1) == {1'b0, lim[g]});
    assign fresh[g] = !raw_q[g] || clr[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt[g] <= '0;
      else if (!stall[g])        cnt[g] <= '0;
      else if (cnt[g] < lim[g])  cnt[g] <= cnt[g] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       raw_q[g] <= 1'b0;
      else if (hit[g])  raw_q[g] <= 1'b1;
      else if (clr[g])  raw_q[g] <= 1'b0;
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      !stall[g] |=> cnt[g] == '0);                                   // R3
    AST_ZERO_LIMIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (lim[g] == '0) && !raw_q[g] |=> !raw_q[g]);                    // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      clr[g] && !hit[g] |=> !raw_q[g]);                              // R8
    AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_q[g] && !hit[g] |=> !raw_q[g]);                           // R2
  end

  wire [WA+1:0] ib_now = {ib_ldst, ib_wr, ib_addr[ADDR_W-1:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ib_rec0 <= '0;
      ib_rec1 <= '0;
    end else if (hit[0]) begin
      ib_rec1 <= ib_now;
      if (fresh[0]) ib_rec0 <= ib_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_info0 <= '0; db_addr0 <= '0; db_pc0 <= '0;
      db_info1 <= '0; db_addr1 <= '0; db_pc1 <= '0;
    end else if (hit[1]) begin
      db_info1 <= {db_be, db_wr};
      db_addr1 <= db_addr[ADDR_W-1:2];
      db_pc1   <= pc;
      if (fresh[1]) begin
        db_info0 <= {db_be, db_wr};
        db_addr0 <= db_addr[ADDR_W-1:2];
        db_pc0   <= pc;
      end
    end
  end

  AST_FIRST_KEPT_IB: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q[0] && !clr[0] |=> $stable(ib_rec0));                       // R7
  AST_FIRST_KEPT_DB: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q[1] && !clr[1] |=> $stable(db_pc0) && $stable(db_addr0));   // R7
endmodule

// File: tb/test_bus_stall_recorder.sv
module test_bus_stall_recorder;
  logic clk = 0, rst_n = 0;
  logic [1:0] mon_en = 0, irq_en = 0, clr = 0;
  logic [19:0] lim_ib = 0, lim_db = 0;
  logic ib_req = 0, ib_busy = 0, ib_wr = 0, ib_ldst = 0;
  logic db_req = 0, db_busy = 0, db_wr = 0;
  logic [31:0] ib_addr = 0, db_addr = 0, pc = 0;
  logic [3:0] db_be = 0;
  logic [1:0] raw;
  logic irq;
  logic [31:0] ib_rec0, ib_rec1, db_pc0, db_pc1;
  logic [4:0] db_info0, db_info1;
  logic [29:0] db_addr0, db_addr1;

  bus_stall_recorder i_bus_stall_recorder (.*);

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int mcnt [2];
  bit mraw [2];
  logic [31:0] m_ib0, m_ib1, m_dp0, m_dp1;
  logic [4:0]  m_di0, m_di1;
  logic [29:0] m_da0, m_da1;

  task automatic chk(string tag, string fld, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "raw", raw, {mraw[1], mraw[0]});
    chk(tag, "irq(R9)", irq, (mraw[0] & irq_en[0]) | (mraw[1] & irq_en[1]));
    chk(tag, "ib_rec0(R5)", ib_rec0, m_ib0);
    chk(tag, "ib_rec1(R5)", ib_rec1, m_ib1);
    chk(tag, "db_info(R6)", {db_info0, db_info1}, {m_di0, m_di1});
    chk(tag, "db_addr(R6)", {db_addr0, db_addr1}, {m_da0, m_da1});
    chk(tag, "db_pc(R6)", {db_pc0, db_pc1}, {m_dp0, m_dp1});
  endtask

  function automatic bit model_hit(int i, bit st, int lim);
    return st && lim != 0 && (mcnt[i] + 1 == lim);
  endfunction

  task automatic tick(string tag);
    bit st [2];
    bit h  [2];
    int lm [2];
    logic [31:0] ibv;
    st[0] = mon_en[0] & ib_req & ib_busy;
    st[1] = mon_en[1] & db_req & db_busy;
    lm[0] = lim_ib; lm[1] = lim_db;
    ibv = {ib_ldst, ib_wr, ib_addr[31:2]};
    for (int i = 0; i < 2; i++) h[i] = model_hit(i, st[i], lm[i]);
    @(posedge clk); #1;
    if (h[0]) begin
      if (!mraw[0] || clr[0]) m_ib0 = ibv;
      m_ib1 = ibv;
    end
    if (h[1]) begin
      if (!mraw[1] || clr[1]) begin m_di0 = {db_be, db_wr}; m_da0 = db_addr[31:2]; m_dp0 = pc; end
      m_di1 = {db_be, db_wr}; m_da1 = db_addr[31:2]; m_dp1 = pc;
    end
    for (int i = 0; i < 2; i++) begin
      if (!st[i]) mcnt[i] = 0;
      else if (mcnt[i] < lm[i]) mcnt[i]++;
      if (h[i]) mraw[i] = 1;
      else if (clr[i]) mraw[i] = 0;
    end
    compare_all(tag);
  endtask

  task automatic idle_clear(string tag);
    ib_req = 0; db_req = 0; clr = 2'b11;
    tick(tag);
    clr = 0;
    tick(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    mcnt[0] = 0; mcnt[1] = 0; mraw[0] = 0; mraw[1] = 0;
    m_ib0 = 0; m_ib1 = 0; m_dp0 = 0; m_dp1 = 0;
    m_di0 = 0; m_di1 = 0; m_da0 = 0; m_da1 = 0;
    repeat (3) @(posedge clk);
    #1 compare_all("R1");
    rst_n = 1;
    tick("R1");

    // R2 and R10: one long instruction stall, limit 3
    mon_en = 2'b11; irq_en = 2'b01; lim_ib = 3;
    ib_req = 1; ib_busy = 1; ib_addr = 32'h0000_1234; ib_wr = 1; ib_ldst = 0;
    for (int k = 0; k < 3; k++) tick("R2");
    for (int k = 0; k < 6; k++) begin ib_addr = ib_addr + 4; tick("R10"); end
    // R10 and R7: a new stall re-flags and moves slot 1 only
    ib_busy = 0; tick("R10");
    ib_busy = 1; ib_addr = 32'hABCD_0010; ib_ldst = 1;
    for (int k = 0; k < 4; k++) tick("R7");
    idle_clear("R8");

    // R3: stalls interrupted by ready, dropped request and disable
    lim_ib = 4; ib_req = 1;
    for (int k = 0; k < 3; k++) begin ib_busy = 1; tick("R3"); end
    ib_busy = 0; tick("R3");
    for (int k = 0; k < 3; k++) begin ib_busy = 1; tick("R3"); end
    ib_req = 0; tick("R3");
    ib_req = 1;
    for (int k = 0; k < 3; k++) tick("R3");
    mon_en = 2'b10; tick("R3");
    mon_en = 2'b11;
    for (int k = 0; k < 3; k++) tick("R3");

    // R4: zero limit never flags
    ib_busy = 0; tick("R4");
    lim_ib = 0; lim_db = 0; ib_busy = 1; db_req = 1; db_busy = 1;
    for (int k = 0; k < 30; k++) tick("R4");

    // R8: clear in the very cycle of a timeout
    db_req = 0; lim_ib = 2; ib_busy = 1; ib_addr = 32'h0000_0100;
    for (int k = 0; k < 2; k++) tick("R8");
    ib_busy = 0; tick("R8");
    ib_busy = 1; ib_addr = 32'h0000_0200; tick("R8");
    clr = 2'b01; tick("R8");
    clr = 0; tick("R8");
    ib_busy = 0; clr = 2'b01; tick("R8");
    clr = 0; tick("R8");

    // R11 and R6: both buses stalled, different limits
    irq_en = 2'b10; lim_ib = 5; lim_db = 2;
    ib_req = 1; ib_busy = 1; db_req = 1; db_busy = 1;
    db_addr = 32'h2000_00FC; db_be = 4'b1010; db_wr = 1; pc = 32'h4000_0044;
    for (int k = 0; k < 6; k++) begin pc = pc + 4; tick("R11"); end
    idle_clear("R9");

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      if (k % 200 == 0) begin
        lim_ib = 20'($urandom_range(0, 6));
        lim_db = 20'($urandom_range(1, 6));
        irq_en = 2'($urandom);
        mon_en = ($urandom % 8 == 0) ? 2'($urandom) : 2'b11;
      end
      ib_req = ($urandom % 10) != 0; ib_busy = ($urandom % 6) != 0;
      db_req = ($urandom % 10) != 0; db_busy = ($urandom % 6) != 0;
      ib_addr = $urandom; ib_wr = 1'($urandom); ib_ldst = 1'($urandom);
      db_addr = $urandom; db_wr = 1'($urandom); db_be = 4'($urandom);
      pc = $urandom;
      clr = ($urandom % 40 == 0) ? 2'($urandom) : 2'b00;
      tick((k % 2 == 0) ? "R7" : "R6");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule